// File: doc/BRIEF.md
# Two-Wire Register Slave with Write Protection

This block is the serial front end of a small register-mapped device such as a clock/calendar. It watches a two-wire bus (clock line and open-drain data line), picks out start and stop conditions, and compares each slave address byte with a fixed 4-bit identifier and 3 select bits. When the address matches, it takes a word address into an internal pointer. It then either stores the data bytes that follow into an external register file or streams register contents back to the bus master. The pointer advances by one after every data byte.

Acknowledge is selective. Data bytes are refused (not acknowledged and not stored) when the external write-enable input is low. A write that reaches the status register stores one byte and refuses every byte after it. A stop that ends a read sequence raises a standby flag, and the next start clears it. Both bus lines are brought into the system clock domain through flop chains, and the data line is only ever pulled low through an output enable.

Top module: `i2c_reg_slave`

## Requirements
- R1: Before the first start condition the slave ignores the bus. Clocked bytes get no acknowledge and cause no register write. A start (data line falling while the clock line is high) is recognised in any state.
- R2: The slave only pulls the data line low, through `sda_oe_o`. The enable changes only while the clock line is low, except when a start or stop clears it.
- R3: An address byte is acknowledged only when bits [7:4] equal `DEV_ID` and bits [3:1] equal `DEV_SEL`. Bit 0 is the direction: 0 means write, 1 means read. On a mismatch the slave releases the line and ignores all bytes until the next start.
- R4: In a write, the first byte after the address is the word address. It is acknowledged and loaded into the pointer. Each following data byte is acknowledged, driven on the register port with a single-cycle `reg_we_o` at the current pointer, and the pointer then increments.
- R5: While `wr_enable_i` is low, data bytes of a write are not acknowledged and produce no `reg_we_o`. The word-address byte is still acknowledged.
- R6: Once a data byte has been stored at `STATUS_ADDR` (default 0x3F), every further data byte of that transaction is not acknowledged and not stored.
- R7: In a read, bytes are sent MSB first starting at the pointer, and the pointer increments per byte. A master acknowledge continues the read. A master not-acknowledge ends it, and the pointer is left at the address after the last byte sent.
- R8: A repeated start returns the slave to address reception and keeps the pointer. A read begun this way starts at the word address given before the repeated start.
- R9: A stop after a read transaction sets `standby_o`. A stop after a write leaves it low. The next start clears it.
- R10: After reset `sda_oe_o`, `reg_we_o` and `standby_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than the bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe_o | output | 1 | Pulls the data line low when high |
| reg_addr_o | output | 8 | Register file address (current pointer) |
| reg_wdata_o | output | 8 | Register file write data |
| reg_we_o | output | 1 | Register file write strobe, one cycle |
| reg_rdata_i | input | 8 | Register file read data for `reg_addr_o` |
| wr_enable_i | input | 1 | Data writes allowed when high |
| standby_o | output | 1 | Set by a stop that ends a read |

## Verification
The address path is tried with a matching byte and with bytes that are wrong only in the identifier or only in the select field. Each mismatch must give no acknowledge and no writes on later bytes. Writes are run with the enable high and low, and as a two-byte burst into the status register. These runs separate acknowledge of the word address from acknowledge of data, and a first data byte from a second one. Reads use a repeated start after a word address, a multi-byte burst ended by not-acknowledge, and a later read with no word address. Together they show that the pointer is loaded, incremented, and kept across transactions, and that the standby flag follows only read-then-stop.

// File: rtl/i2c_reg_slave_pkg.sv
package i2c_reg_slave_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DEV,
    PH_WADR,
    PH_WDAT,
    PH_RDAT
  } phase_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o
);
  localparam int unsigned LAST = SYNC_STAGES;

  // stages [0..SYNC_STAGES-1] synchronize, the extra stage holds the previous value
  logic [LAST:0] scl_p, sda_p;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[LAST-1:0], scl_i};
      sda_p <= {sda_p[LAST-1:0], sda_i};
    end
  end

  logic scl_s, scl_d, sda_s, sda_d;
  assign scl_s = scl_p[LAST-1];
  assign scl_d = scl_p[LAST];
  assign sda_s = sda_p[LAST-1];
  assign sda_d = sda_p[LAST];

  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_d;
  assign scl_fall_o = ~scl_s & scl_d;
  assign start_o    = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_o     = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_reg_core.sv
module i2c_reg_core
  import i2c_reg_slave_pkg::*;
#(
  parameter logic [3:0] DEV_ID      = 4'b1101,
  parameter logic [2:0] DEV_SEL     = 3'b111,
  parameter logic [7:0] STATUS_ADDR = 8'h3F
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic [BYTE_W-1:0] rdata_i,
  input  logic              wr_enable_i,
  output logic              sda_oe_o,
  output logic [BYTE_W-1:0] addr_o,
  output logic [BYTE_W-1:0] wdata_o,
  output logic              we_o,
  output logic              standby_o
);
  localparam int unsigned CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  phase_e            phase_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              in_ack_q, ack_m_q, rw_q, rd_seen_q, st_lock_q;
  logic              oe_q, we_q, standby_q;
  logic [BYTE_W-1:0] sh_q, ptr_q, wdata_q;
  logic [BYTE_W-2:0] tx_q;

  logic addr_hit, wr_ok;
  assign addr_hit = (sh_q[7:4] == DEV_ID) && (sh_q[3:1] == DEV_SEL);
  assign wr_ok    = wr_enable_i && !st_lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_IDLE;
      cnt_q     <= '0;
      in_ack_q  <= 1'b0;
      ack_m_q   <= 1'b0;
      rw_q      <= 1'b0;
      rd_seen_q <= 1'b0;
      st_lock_q <= 1'b0;
      oe_q      <= 1'b0;
      we_q      <= 1'b0;
      standby_q <= 1'b0;
      sh_q      <= '0;
      ptr_q     <= '0;
      wdata_q   <= '0;
      tx_q      <= '0;
    end else begin
      we_q <= 1'b0;
      if (we_q) ptr_q <= ptr_q + BYTE_W'(1);
      if (start_i) begin
        phase_q   <= PH_DEV;
        cnt_q     <= '0;
        in_ack_q  <= 1'b0;
        oe_q      <= 1'b0;
        st_lock_q <= 1'b0;
        rd_seen_q <= 1'b0;
        standby_q <= 1'b0;
      end else if (stop_i) begin
        phase_q   <= PH_IDLE;
        in_ack_q  <= 1'b0;
        oe_q      <= 1'b0;
        standby_q <= rd_seen_q;
      end else if (phase_q == PH_RDAT) begin
        if (scl_rise_i) begin
          if (in_ack_q) ack_m_q <= ~sda_i;
          else          cnt_q   <= cnt_q + CNT_W'(1);
        end
        if (scl_fall_i) begin
          if (in_ack_q) begin
            in_ack_q <= 1'b0;
            cnt_q    <= '0;
            if (ack_m_q) begin
              tx_q  <= rdata_i[BYTE_W-2:0];
              oe_q  <= ~rdata_i[BYTE_W-1];
              ptr_q <= ptr_q + BYTE_W'(1);
            end else begin
              phase_q <= PH_IDLE;
            end
          end else if (cnt_q == FULL) begin
            oe_q     <= 1'b0;   // release for master acknowledge
            in_ack_q <= 1'b1;
          end else begin
            oe_q <= ~tx_q[BYTE_W-2];
            tx_q <= {tx_q[BYTE_W-3:0], 1'b0};
          end
        end
      end else if (phase_q != PH_IDLE) begin
        if (scl_rise_i && !in_ack_q) begin
          sh_q  <= {sh_q[BYTE_W-2:0], sda_i};
          cnt_q <= cnt_q + CNT_W'(1);
        end
        if (scl_fall_i) begin
          if (in_ack_q) begin
            in_ack_q <= 1'b0;
            cnt_q    <= '0;
            oe_q     <= 1'b0;
            case (phase_q)
              PH_DEV: begin
                if (rw_q) begin
                  phase_q <= PH_RDAT;
                  tx_q    <= rdata_i[BYTE_W-2:0];
                  oe_q    <= ~rdata_i[BYTE_W-1];
                  ptr_q   <= ptr_q + BYTE_W'(1);
                end else begin
                  phase_q <= PH_WADR;
                end
              end
              PH_WADR: phase_q <= PH_WDAT;
              default: ;
            endcase
          end else if (cnt_q == FULL) begin
            in_ack_q <= 1'b1;
            case (phase_q)
              PH_DEV: begin
                if (addr_hit) begin
                  oe_q      <= 1'b1;
                  rw_q      <= sh_q[0];
                  rd_seen_q <= sh_q[0];
                end else begin
                  phase_q <= PH_IDLE;
                end
              end
              PH_WADR: begin
                oe_q  <= 1'b1;
                ptr_q <= sh_q;
              end
              PH_WDAT: begin
                if (wr_ok) begin
                  oe_q    <= 1'b1;
                  we_q    <= 1'b1;
                  wdata_q <= sh_q;
                  if (ptr_q == STATUS_ADDR) st_lock_q <= 1'b1;
                end
              end
              default: ;
            endcase
          end
        end
      end
    end
  end

  assign sda_oe_o  = oe_q;
  assign addr_o    = ptr_q;
  assign wdata_o   = wdata_q;
  assign we_o      = we_q;
  assign standby_o = standby_q;

  assert_oe_moves_on_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_q != $past(oe_q)) |-> ($past(scl_fall_i) || $past(start_i) || $past(stop_i)));

  assert_idle_released_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_IDLE) |-> !oe_q);

  assert_we_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_q |=> !we_q);

  assert_we_needs_enable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_q |-> $past(wr_enable_i));

  assert_status_once_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_q |-> !$past(st_lock_q));
endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave #(
  parameter logic [3:0]  DEV_ID      = 4'b1101,
  parameter logic [2:0]  DEV_SEL     = 3'b111,
  parameter logic [7:0]  STATUS_ADDR = 8'h3F,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  output logic [7:0] reg_addr_o,
  output logic [7:0] reg_wdata_o,
  output logic       reg_we_o,
  input  logic [7:0] reg_rdata_i,
  input  logic       wr_enable_i,
  output logic       standby_o
);
  logic sda_s, start_w, stop_w, rise_w, fall_w;

  i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_o      (sda_s),
    .start_o    (start_w),
    .stop_o     (stop_w),
    .scl_rise_o (rise_w),
    .scl_fall_o (fall_w)
  );

  i2c_reg_core #(
    .DEV_ID      (DEV_ID),
    .DEV_SEL     (DEV_SEL),
    .STATUS_ADDR (STATUS_ADDR)
  ) u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sda_i       (sda_s),
    .start_i     (start_w),
    .stop_i      (stop_w),
    .scl_rise_i  (rise_w),
    .scl_fall_i  (fall_w),
    .rdata_i     (reg_rdata_i),
    .wr_enable_i (wr_enable_i),
    .sda_oe_o    (sda_oe_o),
    .addr_o      (reg_addr_o),
    .wdata_o     (reg_wdata_o),
    .we_o        (reg_we_o),
    .standby_o   (standby_o)
  );

  assert_standby_from_stop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(standby_o) |-> $past(stop_w));

  assert_start_clears_standby_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_w |=> !standby_o);
endmodule

// File: tb/i2c_reg_slave_test.sv
module i2c_reg_slave_test;
  localparam int CLK_P = 10;
  localparam int QTR   = 8;
  localparam logic [7:0] A_WR = 8'hDE;
  localparam logic [7:0] A_RD = 8'hDF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic low_m = 1'b0;
  logic wren = 1'b1;
  logic sda_oe, we, standby;
  logic [7:0] addr, wdata, rdata;
  logic sda_bus;

  logic [7:0] mem [256];
  int wr_cnt = 0;
  logic pl_en = 1'b0;
  logic [7:0] pl_addr = '0, pl_data = '0;

  int checks = 0, errors = 0, oe_viol = 0;
  logic oe_prev = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  assign sda_bus = ~(low_m | sda_oe);
  assign rdata   = mem[addr];

  i2c_reg_slave uut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .reg_addr_o(addr), .reg_wdata_o(wdata), .reg_we_o(we),
    .reg_rdata_i(rdata), .wr_enable_i(wren), .standby_o(standby)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'h00;
    end else if (pl_en) begin
      mem[pl_addr] <= pl_data;
    end else if (we) begin
      mem[addr] <= wdata;
      wr_cnt <= wr_cnt + 1;
    end
  end

  // R2: enable must not move while the clock line is high
  always @(posedge clk) begin
    oe_prev <= sda_oe;
    if (rst_n && (oe_prev != sda_oe) && scl_m) oe_viol <= oe_viol + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n = 1);
    repeat (n * QTR) @(negedge clk);
  endtask

  task automatic bus_start();
    low_m = 1'b0; wq();
    scl_m = 1'b1; wq();
    low_m = 1'b1; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    low_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    low_m = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      low_m = ~b[i]; wq();
      scl_m = 1'b1; wq(2);
      scl_m = 1'b0; wq();
    end
    low_m = 1'b0; wq();
    scl_m = 1'b1; wq();
    ack = ~sda_bus;
    wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    low_m = 1'b0;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      wq();
      scl_m = 1'b1; wq();
      b = {b[6:0], sda_bus};
      wq();
      scl_m = 1'b0; wq();
    end
    low_m = mack; wq();
    scl_m = 1'b1; wq(2);
    scl_m = 1'b0; wq();
    low_m = 1'b0;
  endtask

  task automatic preload(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); pl_addr = a; pl_data = d; pl_en = 1'b1;
    @(negedge clk); pl_en = 1'b0;
  endtask

  task automatic t_reset();
    chk(sda_oe == 1'b0, "R10 oe", sda_oe, 0);
    chk(we == 1'b0, "R10 we", we, 0);
    chk(standby == 1'b0, "R10 standby", standby, 0);
  endtask

  task automatic t_no_start();
    bit ack;
    int w0 = wr_cnt;
    scl_m = 1'b0; wq();
    send_byte(A_WR, ack);
    chk(!ack, "R1 address before start", ack, 0);
    send_byte(8'h05, ack);
    chk(!ack && wr_cnt == w0, "R1 byte before start", wr_cnt, w0);
  endtask

  task automatic t_write();
    bit ack;
    bus_start();
    send_byte(A_WR, ack);  chk(ack, "R3 address match", ack, 1);
    send_byte(8'h10, ack); chk(ack, "R4 word address ack", ack, 1);
    send_byte(8'hA5, ack); chk(ack, "R4 data ack 0", ack, 1);
    send_byte(8'h3C, ack); chk(ack, "R4 data ack 1", ack, 1);
    bus_stop();
    chk(mem[8'h10] == 8'hA5, "R4 mem 0x10", mem[8'h10], 8'hA5);
    chk(mem[8'h11] == 8'h3C, "R4 mem 0x11", mem[8'h11], 8'h3C);
    chk(standby == 1'b0, "R9 stop after write", standby, 0);
  endtask

  task automatic t_mismatch(input logic [7:0] a, input string tag);
    bit ack;
    int w0 = wr_cnt;
    bus_start();
    send_byte(a, ack);     chk(!ack, {"R3 no ack ", tag}, ack, 0);
    send_byte(8'h50, ack); chk(!ack, {"R3 ignored word ", tag}, ack, 0);
    send_byte(8'h99, ack);
    chk(!ack && wr_cnt == w0, {"R3 ignored data ", tag}, wr_cnt, w0);
    bus_stop();
  endtask

  task automatic t_protect();
    bit ack;
    int w0 = wr_cnt;
    wren = 1'b0;
    bus_start();
    send_byte(A_WR, ack);  chk(ack, "R5 address ack", ack, 1);
    send_byte(8'h30, ack); chk(ack, "R5 word address still ack", ack, 1);
    send_byte(8'h77, ack); chk(!ack, "R5 data refused", ack, 0);
    send_byte(8'h88, ack); chk(!ack, "R5 data refused 2", ack, 0);
    bus_stop();
    chk(wr_cnt == w0, "R5 no write strobe", wr_cnt, w0);
    chk(mem[8'h30] == 8'h00, "R5 mem 0x30", mem[8'h30], 0);
    wren = 1'b1;
  endtask

  task automatic t_status();
    bit ack;
    int w0 = wr_cnt;
    bus_start();
    send_byte(A_WR, ack);
    send_byte(8'h3F, ack); chk(ack, "R6 word address ack", ack, 1);
    send_byte(8'h5A, ack); chk(ack, "R6 first byte ack", ack, 1);
    send_byte(8'h6B, ack); chk(!ack, "R6 second byte refused", ack, 0);
    bus_stop();
    chk(mem[8'h3F] == 8'h5A, "R6 mem 0x3F", mem[8'h3F], 8'h5A);
    chk(mem[8'h40] == 8'h00, "R6 mem 0x40", mem[8'h40], 0);
    chk(wr_cnt == w0 + 1, "R6 one strobe", wr_cnt, w0 + 1);
  endtask

  task automatic t_read();
    bit ack;
    logic [7:0] b;
    preload(8'h20, 8'h11); preload(8'h21, 8'h22);
    preload(8'h22, 8'h33); preload(8'h23, 8'h44);
    bus_start();
    send_byte(A_WR, ack);
    send_byte(8'h20, ack);
    bus_start();           // repeated start, pointer kept
    send_byte(A_RD, ack);  chk(ack, "R8 read address after repeated start", ack, 1);
    recv_byte(1'b1, b);    chk(b == 8'h11, "R8 first byte at word address", b, 8'h11);
    recv_byte(1'b1, b);    chk(b == 8'h22, "R7 second byte", b, 8'h22);
    recv_byte(1'b0, b);    chk(b == 8'h33, "R7 last byte", b, 8'h33);
    chk(sda_oe == 1'b0, "R7 released after nack", sda_oe, 0);
    bus_stop();
    wq();
    chk(standby == 1'b1, "R9 standby after read", standby, 1);
    bus_start();
    chk(standby == 1'b0, "R9 start clears standby", standby, 0);
    send_byte(A_RD, ack);
    recv_byte(1'b0, b);    chk(b == 8'h44, "R7 pointer continues", b, 8'h44);
    bus_stop();
    wq();
    chk(standby == 1'b1, "R9 standby second read", standby, 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    wq();
    t_no_start();
    t_write();
    t_mismatch(8'h5E, "id");
    t_mismatch(8'hDA, "select");
    t_protect();
    t_status();
    t_read();
    bus_start();
    chk(standby == 1'b0, "R9 cleared by start", standby, 0);
    bit_dummy_write();
    chk(oe_viol == 0, "R2 enable moves only with clock low", oe_viol, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic bit_dummy_write();
    bit ack;
    send_byte(A_WR, ack);
    send_byte(8'h60, ack);
    send_byte(8'h01, ack);
    bus_stop();
    wq();
    chk(standby == 1'b0 && mem[8'h60] == 8'h01, "R9 write stop keeps standby low", standby, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule